// File: doc/BRIEF.md
# Ring Oscillator Path-Sweep Frequency Meter

This controller measures the speed of every internal path through a set of ring oscillators built from 4-input lookup tables. The oscillators are seven-stage loops: input I0 of each stage carries the ring signal, and the three remaining inputs form a 3-bit path code that picks one of eight routes through the table. The block drives that code and a mapping select. For even-parity codes it requests the XNOR table contents, and for odd-parity codes the XOR contents, so every stage stays inverting and the loop keeps oscillating. It also drives a one-hot enable that picks one oscillator at a time.

For each oscillator and each path, the block waits a fixed settling time. It then counts rising edges of the synchronized oscillator signal over ten consecutive windows of the reference clock, divides the total by ten with a constant multiply-and-shift, and offers the average on a valid/ready port tagged with oscillator and path indices. The results leave in path order within each oscillator, and in oscillator order overall. Together they form the per-device frequency array. After the last result is accepted the block raises `done`, and a new `start` runs the sweep again.

Top module: `ro_path_sweep`

## Requirements
- R1: While `rst` is high and in the cycle after it, `busy`, `done`, `rd_valid` and `ro_en` are all zero.
- R2: Results come out oscillator by oscillator, and within each oscillator with path codes 0 to 7 ascending. `rd_osc` and `rd_path` carry the indices of the value on `rd_avg`.
- R3: While busy, `map_xor` equals the XOR of the three `path_sel` bits: 0 selects the XNOR contents (even parity) and 1 selects the XOR contents (odd parity).
- R4: While busy, `ro_en` has exactly one bit set, at the position of the oscillator under test. When not busy it is zero.
- R5: A result becomes valid exactly SETTLE + REPEATS*WINDOW + 1 cycles after the `start` pulse or the previous handshake. No edge during the SETTLE cycles is counted.
- R6: `rd_avg` equals floor(E / REPEATS), where E is the number of rising edges of the selected oscillator over REPEATS back-to-back windows of WINDOW reference cycles each. The division is exact over the full range of E.
- R7: An oscillator that does not toggle yields an average of 0 on all eight paths.
- R8: While `rd_valid` is high and `rd_ready` is low, `rd_valid` stays high and `rd_avg`, `rd_osc` and `rd_path` hold their values.
- R9: After the last result (last oscillator, path 7) is accepted, `done` is high and `busy` low, with no further results. A new `start` begins a fresh sweep.
- R10: `path_sel` and `ro_en` change only on the cycle after a `start` or a result handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock that gates the counting windows |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a sweep (accepted when idle or done) |
| ro_in | input | NUM_RO | Asynchronous oscillator outputs |
| ro_en | output | NUM_RO | One-hot enable of the oscillator under test |
| path_sel | output | 3 | Path code driven onto the three non-feedback stage inputs |
| map_xor | output | 1 | 1 = XOR table contents, 0 = XNOR table contents |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | Sweep finished, all results delivered |
| rd_valid | output | 1 | Result available |
| rd_ready | input | 1 | Consumer accepts the result |
| rd_avg | output | SUM_W | Averaged edge count per window |
| rd_osc | output | OSC_W | Oscillator index of the result |
| rd_path | output | 3 | Path code of the result |

## Verification
A corrupted sweep state shows at the readout on the next result: a path skipped or repeated is visible in `rd_path` and `rd_osc` within one measurement interval. A wrong window length or a leaky settle phase moves both the latency of the next `rd_valid` and its value. A wrong divide constant shows up as an off-by-one average on the first path whose edge total is not a multiple of ten. A mapping select out of step with the path code is visible on `map_xor` the same cycle the code changes.

// File: rtl/ro_sweep_pkg.sv
package ro_sweep_pkg;
  localparam int LUT_INPUTS = 4;
  localparam int PATH_BITS  = LUT_INPUTS - 1;
  localparam int NUM_PATHS  = 1 << PATH_BITS;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_COUNT,
    ST_AVG,
    ST_STORE,
    ST_DONE
  } sweep_st_t;
endpackage

// File: rtl/ro_edge_sync.sv
module ro_edge_sync (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= async_in;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign rise = sync_q & ~prev_q;
endmodule

// File: rtl/ro_div_const.sv
module ro_div_const #(
  parameter int IN_W    = 10,
  parameter int DIVISOR = 10
) (
  input  logic [IN_W-1:0] num,
  output logic [IN_W-1:0] quo
);
  // Rounding error e of the reciprocal is below DIVISOR <= 2^SHIFT_X,
  // so num*e < 2^S for every num < 2^IN_W and the quotient is exact.
  localparam int SHIFT_X = $clog2(DIVISOR);
  localparam int S       = IN_W + SHIFT_X;
  localparam int PW      = IN_W + S;
  localparam logic [S-1:0] RECIP =
    S'(((64'd1 << S) + 64'(DIVISOR) - 64'd1) / 64'(DIVISOR));

  logic [PW-1:0] prod;

  assign prod = {{S{1'b0}}, num} * {{IN_W{1'b0}}, RECIP};
  assign quo  = IN_W'(prod >> S);
endmodule

// File: rtl/ro_path_sweep.sv
module ro_path_sweep
  import ro_sweep_pkg::*;
#(
  parameter int NUM_RO  = 4,
  parameter int WINDOW  = 64,
  parameter int REPEATS = 10,
  parameter int SETTLE  = 16,
  localparam int OSC_W  = (NUM_RO > 1) ? $clog2(NUM_RO) : 1,
  localparam int TOTAL  = REPEATS * WINDOW,
  localparam int SUM_W  = $clog2(TOTAL + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic [NUM_RO-1:0]    ro_in,
  output logic [NUM_RO-1:0]    ro_en,
  output logic [PATH_BITS-1:0] path_sel,
  output logic                 map_xor,
  output logic                 busy,
  output logic                 done,
  output logic                 rd_valid,
  input  logic                 rd_ready,
  output logic [SUM_W-1:0]     rd_avg,
  output logic [OSC_W-1:0]     rd_osc,
  output logic [PATH_BITS-1:0] rd_path
);
  localparam int TMR_MAX = (TOTAL > SETTLE) ? TOTAL : SETTLE;
  localparam int TMR_W   = $clog2(TMR_MAX + 1);

  sweep_st_t           state;
  logic [OSC_W-1:0]    osc_q;
  logic [TMR_W-1:0]    tmr_q;
  logic [SUM_W-1:0]    sum_q;
  logic [SUM_W-1:0]    quo;
  logic [NUM_RO-1:0]   rise_vec;
  logic                edge_sel;
  logic [PATH_BITS-1:0] path_nxt;

  // One synchronizer and edge detector per oscillator input
  for (genvar g = 0; g < NUM_RO; g++) begin : g_sync
    ro_edge_sync u_sync (
      .clk      (clk),
      .rst      (rst),
      .async_in (ro_in[g]),
      .rise     (rise_vec[g])
    );
  end

  assign edge_sel = rise_vec[osc_q];
  assign path_nxt = path_sel + 1'b1;

  ro_div_const #(
    .IN_W    (SUM_W),
    .DIVISOR (REPEATS)
  ) u_div (
    .num (sum_q),
    .quo (quo)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      osc_q    <= '0;
      tmr_q    <= '0;
      sum_q    <= '0;
      ro_en    <= '0;
      path_sel <= '0;
      map_xor  <= 1'b0;
      busy     <= 1'b0;
      done     <= 1'b0;
      rd_valid <= 1'b0;
      rd_avg   <= '0;
      rd_osc   <= '0;
      rd_path  <= '0;
    end else begin
      case (state)
        ST_IDLE, ST_DONE: begin
          if (start) begin
            osc_q    <= '0;
            path_sel <= '0;
            map_xor  <= 1'b0;
            ro_en    <= NUM_RO'(1);
            busy     <= 1'b1;
            done     <= 1'b0;
            tmr_q    <= '0;
            state    <= ST_SETTLE;
          end
        end
        ST_SETTLE: begin
          if (tmr_q == TMR_W'(SETTLE - 1)) begin
            tmr_q <= '0;
            sum_q <= '0;
            state <= ST_COUNT;
          end else begin
            tmr_q <= tmr_q + 1'b1;
          end
        end
        ST_COUNT: begin
          sum_q <= sum_q + SUM_W'(edge_sel);
          if (tmr_q == TMR_W'(TOTAL - 1)) begin
            tmr_q <= '0;
            state <= ST_AVG;
          end else begin
            tmr_q <= tmr_q + 1'b1;
          end
        end
        ST_AVG: begin
          rd_avg   <= quo;
          rd_osc   <= osc_q;
          rd_path  <= path_sel;
          rd_valid <= 1'b1;
          state    <= ST_STORE;
        end
        ST_STORE: begin
          if (rd_ready) begin
            rd_valid <= 1'b0;
            tmr_q    <= '0;
            if (path_sel == PATH_BITS'(NUM_PATHS - 1)) begin
              if (osc_q == OSC_W'(NUM_RO - 1)) begin
                busy  <= 1'b0;
                done  <= 1'b1;
                ro_en <= '0;
                state <= ST_DONE;
              end else begin
                osc_q    <= osc_q + 1'b1;
                ro_en    <= ro_en << 1;
                path_sel <= '0;
                map_xor  <= 1'b0;
                state    <= ST_SETTLE;
              end
            end else begin
              path_sel <= path_nxt;
              map_xor  <= ^path_nxt;
              state    <= ST_SETTLE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ro_path_sweep_chk.sv
module ro_path_sweep_chk #(
  parameter int NUM_RO = 4,
  parameter int AVG_W  = 10,
  parameter int OSC_W  = 2,
  parameter int WINDOW = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic [NUM_RO-1:0] ro_en,
  input logic [2:0]        path_sel,
  input logic              map_xor,
  input logic              busy,
  input logic              done,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic [AVG_W-1:0]  rd_avg,
  input logic [OSC_W-1:0]  rd_osc,
  input logic [2:0]        rd_path
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!busy && !done && !rd_valid && ro_en == '0));

  assert_tag_match_R2: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> (rd_path == path_sel && ro_en[rd_osc]));

  assert_map_parity_R3: assert property (@(posedge clk) disable iff (rst)
    busy |-> (map_xor == ^path_sel));

  assert_onehot_en_R4: assert property (@(posedge clk) disable iff (rst)
    busy |-> ($countones(ro_en) == 1));

  assert_idle_en_R4: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (ro_en == '0));

  assert_avg_range_R6: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> (rd_avg <= AVG_W'(WINDOW)));

  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rd_ready) |=>
      (rd_valid && $stable(rd_avg) && $stable(rd_osc) && $stable(rd_path)));

  assert_done_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && !rd_valid));

  assert_sel_fixed_R10: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && !$past(rd_valid && rd_ready)) |->
      ($stable(path_sel) && $stable(ro_en)));

  assert_start_clean_R10: assert property (@(posedge clk) disable iff (rst)
    (!busy && start) |=> (busy && path_sel == 3'd0 && ro_en == NUM_RO'(1)));
endmodule

bind ro_path_sweep ro_path_sweep_chk #(
  .NUM_RO (NUM_RO),
  .AVG_W  (SUM_W),
  .OSC_W  (OSC_W),
  .WINDOW (WINDOW)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .ro_en    (ro_en),
  .path_sel (path_sel),
  .map_xor  (map_xor),
  .busy     (busy),
  .done     (done),
  .rd_valid (rd_valid),
  .rd_ready (rd_ready),
  .rd_avg   (rd_avg),
  .rd_osc   (rd_osc),
  .rd_path  (rd_path)
);

// File: tb/ro_path_sweep_tb.sv
module ro_path_sweep_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_RO  = 4;
  localparam int WINDOW  = 64;
  localparam int REPEATS = 10;
  localparam int SETTLE  = 16;
  localparam int OSC_W   = 2;
  localparam int TOTAL   = REPEATS * WINDOW;
  localparam int SUM_W   = $clog2(TOTAL + 1);
  localparam int LAT     = SETTLE + TOTAL + 1;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start = 1'b0;
  logic              rd_ready = 1'b0;
  logic [NUM_RO-1:0] ro_in = '0;
  logic [NUM_RO-1:0] ro_en;
  logic [2:0]        path_sel;
  logic              map_xor;
  logic              busy;
  logic              done;
  logic              rd_valid;
  logic [SUM_W-1:0]  rd_avg;
  logic [OSC_W-1:0]  rd_osc;
  logic [2:0]        rd_path;

  int n_chk = 0;
  int n_bad = 0;
  int mode = 0;
  logic [NUM_RO-1:0] stall = '0;
  int tcnt [NUM_RO];

  always #(CLK_PERIOD/2) clk = ~clk;

  ro_path_sweep #(
    .NUM_RO (NUM_RO), .WINDOW (WINDOW), .REPEATS (REPEATS), .SETTLE (SETTLE)
  ) u_dut (
    .clk (clk), .rst (rst), .start (start), .ro_in (ro_in),
    .ro_en (ro_en), .path_sel (path_sel), .map_xor (map_xor),
    .busy (busy), .done (done), .rd_valid (rd_valid), .rd_ready (rd_ready),
    .rd_avg (rd_avg), .rd_osc (rd_osc), .rd_path (rd_path)
  );

  function automatic int half_period(int m, int i, int p);
    if (m == 0) return 1 << ((i + p) % 4);
    return 3 + ((i + p) % 3);
  endfunction

  function automatic int expect_avg(int m, int i, int p, logic st);
    if (st) return 0;
    return (TOTAL / (2 * half_period(m, i, p))) / REPEATS;
  endfunction

  // Modelled oscillators: toggle every K reference cycles, K set by path code
  always @(negedge clk) begin
    for (int i = 0; i < NUM_RO; i++) begin
      if (rst || stall[i]) begin
        tcnt[i] = 0;
      end else if (tcnt[i] >= half_period(mode, i, int'(path_sel)) - 1) begin
        tcnt[i] = 0;
        ro_in[i] <= ~ro_in[i];
      end else begin
        tcnt[i] = tcnt[i] + 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_valid(output int n);
    n = 0;
    while (!rd_valid && n < 5000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(!busy && !done && !rd_valid, "R1 flags in reset", {busy, done, rd_valid}, 0);
    check(ro_en == '0, "R1 ro_en in reset", int'(ro_en), 0);
    rst = 1'b0;
    @(negedge clk);
    check(!busy && !done && !rd_valid && ro_en == '0, "R1 after reset",
          {busy, done, rd_valid}, 0);
  endtask

  task automatic t_sweep(input int m, input logic [NUM_RO-1:0] st, input bit bp);
    int n;
    mode  = m;
    stall = st;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int idx = 0; idx < NUM_RO * 8; idx++) begin
      wait_valid(n);
      check(n == LAT, "R5 result latency", n, LAT);
      check(busy, "R4 busy during sweep", busy, 1);
      check(int'(rd_osc) == idx / 8, "R2 oscillator order", rd_osc, idx / 8);
      check(int'(rd_path) == idx % 8, "R2 path order", rd_path, idx % 8);
      check(map_xor == ^rd_path, "R3 mapping parity", map_xor, ^rd_path);
      check(ro_en == NUM_RO'(1) << rd_osc, "R4 oscillator enable", ro_en, 1 << rd_osc);
      if (st[idx / 8])
        check(int'(rd_avg) == 0, "R7 stopped oscillator", rd_avg, 0);
      else
        check(int'(rd_avg) == expect_avg(m, idx / 8, idx % 8, 1'b0), "R6 average",
              rd_avg, expect_avg(m, idx / 8, idx % 8, 1'b0));
      if (bp && (idx % 5 == 0)) begin
        logic [SUM_W-1:0] a0;
        logic [2:0] p0;
        a0 = rd_avg;
        p0 = rd_path;
        repeat (4) @(negedge clk);
        check(rd_valid && rd_avg == a0 && rd_path == p0, "R8 hold under backpressure",
              rd_avg, a0);
      end
      rd_ready = 1'b1;
      @(negedge clk);
      rd_ready = 1'b0;
    end
    repeat (2) @(negedge clk);
    check(done && !busy && !rd_valid, "R9 done after last result", {done, busy, rd_valid}, 4);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_sweep(0, 4'b0000, 1'b0);         // R2 R6: periods dividing the window
    t_sweep(1, 4'b0100, 1'b1);         // R6 R7 R8: non-divisible periods, one stopped
    t_sweep(0, 4'b0001, 1'b0);         // R9 restart from done, R7 on oscillator 0
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule